// File: doc/BRIEF.md
# Uncorrectable-Error Header Log with Multi-Entry Queue

This block keeps the log that an advanced error reporting capability shows for uncorrectable errors. The log has a first-error pointer, a four-word header image, a four-word prefix image and a flag that says whether the prefix image is valid. The block also owns the uncorrectable error status word, because that word decides what happens to the log. The error classifier pulses `rec_valid` with a one-hot status word, the captured header and prefix, and their validity flags. Each recorded error sets its status bit.

When multiple-header recording is enabled and the error at the first-error pointer has not been acknowledged, a new error goes into a bounded first-in first-out queue and the visible log stays as it is. Software acknowledges an error by writing ones to clear status bits. When the bit at the first-error pointer is cleared, the oldest queued error moves into the visible log. If nothing is queued, the log is wiped. While an error waits in the queue, its status bit cannot be cleared. A record that finds the queue full raises a one-cycle overflow pulse, which the surrounding logic turns into a correctable header-log-overflow error.

Top module: `aer_hdr_log_queue`

## Requirements
- R1: On a record, `first_err_ptr` takes the index of the lowest set bit of `rec_status` whenever the record lands in the visible log. Every bit of `rec_status` is ORed into `uncor_status`.
- R2: Header word i is `rec_hdr[32*i+:32]`. It appears in `hdr_log[32*i+:32]` with its bytes reversed: byte k of the image (`hdr_log[32*i+8*k+:8]`) is bits `[8*(3-k)+:8]` of the word. When `rec_hdr_ok` is 0, the header image is all zero.
- R3: The prefix image uses the same byte order, built from `rec_pfx`. It is filled, and `pfx_logged` is set to 1, only when `rec_pfx_ok` and `pfx_en` are both 1 at the time the entry is loaded. Otherwise the prefix image is zero and `pfx_logged` is 0.
- R4: A record arrives while recording is enabled and the status bit at `first_err_ptr` is set. That record is queued, and `first_err_ptr`, `hdr_log`, `pfx_log` and `pfx_logged` keep their values.
- R5: A record that should be queued while the queue holds DEPTH entries is dropped. `log_overflow` is then 1 for exactly the one cycle after that record, and the record's status bit is still set.
- R6: A write clears the status bit at `first_err_ptr` while recording is off or the queue is empty. The pointer, `pfx_logged` and both images then become zero.
- R7: A write clears the status bit at `first_err_ptr` while entries are queued. The status bits of all queued entries are set again, and the oldest entry becomes the visible log, in arrival order.
- R8: A status or control write leaves the status bit at `first_err_ptr` set. If recording is enabled, every status bit of a queued entry that the write cleared is restored. If recording is disabled, the queue is emptied, so a later acknowledge wipes the log instead of loading a queued entry.
- R9: With DEPTH = 0, `mhr_capable` is 0 and `mhr_enabled` stays 0 whatever is written. Every record then overwrites the visible log.
- R10: With recording disabled, every record replaces the visible log.
- R11: After reset, all outputs are zero, except `mhr_capable`, which is 1 when DEPTH > 0.
- R12: A record in the same cycle as a software write is judged against the state after that write, including any entry popped by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record-error strobe |
| rec_status | input | 32 | One-hot status of the error being recorded |
| rec_hdr | input | 128 | Four header words, word i at bits 32*i |
| rec_hdr_ok | input | 1 | Header is valid |
| rec_pfx | input | 128 | Four prefix words |
| rec_pfx_ok | input | 1 | Error carries a prefix |
| pfx_en | input | 1 | End-to-end prefix support enabled |
| stat_we | input | 1 | Software write to the status word |
| stat_clr | input | 32 | Write-one-to-clear mask |
| ctl_we | input | 1 | Software write to capability/control |
| ctl_mhr | input | 1 | Requested multiple-header recording enable |
| uncor_status | output | 32 | Uncorrectable error status word |
| first_err_ptr | output | 5 | First-error pointer |
| hdr_log | output | 128 | Header log byte image |
| pfx_log | output | 128 | Prefix log byte image |
| pfx_logged | output | 1 | Prefix log holds a prefix |
| mhr_enabled | output | 1 | Multiple-header recording enabled |
| mhr_capable | output | 1 | Multiple-header recording supported |
| log_overflow | output | 1 | One-cycle pulse: queue full, record dropped |

## Verification
The first pattern walks a record through each of the 32 status bits with recording off. It shows that the pointer follows the lowest set bit and that every record replaces the view, which would hide a pointer stuck on an earlier value. The next set of records changes the header and prefix flags and the prefix enable one at a time, which separates the byte-reversal rule from the zeroing rules. A burst of five errors into a three-deep queue, followed by acknowledges in order, shows queue order, overflow and status re-assertion. These are kept apart from the discard that a disable causes and from a record that lands in the same cycle as a pop. A second instance with zero depth confirms that the enable cannot be set.

// File: rtl/aer_log_pkg.sv
package aer_log_pkg;

    localparam int STAT_W    = 32;
    localparam int LOG_WORDS = 4;
    localparam int IDX_W     = $clog2(STAT_W);
    localparam int LOG_W     = 32 * LOG_WORDS;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [LOG_W-1:0] hdr;
        logic             hdr_ok;
        logic [LOG_W-1:0] pfx;
        logic             pfx_ok;
    } err_entry_t;

    // Index of the lowest set bit; scanning downward lets the lowest win.
    function automatic logic [IDX_W-1:0] lowest_bit(input logic [STAT_W-1:0] s);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (s[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // Reverse the bytes of every 32-bit word to give the register byte image.
    function automatic logic [LOG_W-1:0] to_byte_image(input logic [LOG_W-1:0] w);
        logic [LOG_W-1:0] o;
        o = '0;
        for (int i = 0; i < LOG_WORDS; i++) begin
            for (int k = 0; k < 4; k++) begin
                o[32*i + 8*k +: 8] = w[32*i + 8*(3-k) +: 8];
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/errlog_view.sv
module errlog_view
    import aer_log_pkg::*;
(
    input  err_entry_t       entry,
    input  logic             pfx_en,
    output logic [LOG_W-1:0] hdr_img,
    output logic [LOG_W-1:0] pfx_img,
    output logic             pfx_flag
);

    logic pfx_take;

    always_comb begin
        pfx_take = entry.pfx_ok && pfx_en;
        hdr_img  = entry.hdr_ok ? to_byte_image(entry.hdr) : '0;
        pfx_img  = pfx_take ? to_byte_image(entry.pfx) : '0;
        pfx_flag = pfx_take;
    end

endmodule

// File: rtl/errq_fifo.sv
module errq_fifo
    import aer_log_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  err_entry_t        din,
    output err_entry_t        head,
    output logic              empty,
    output logic              full,
    output logic [STAT_W-1:0] pend_mask
);

    localparam int SLOTS = (DEPTH > 0) ? DEPTH : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        err_entry_t [SLOTS-1:0] slot;
        logic [CNT_W-1:0]       cnt;
    } fifo_state_t;

    fifo_state_t q, d;

    always_comb begin
        d = q;
        if (flush) begin
            d.cnt = '0;
        end else begin
            if (pop && q.cnt != '0) begin
                for (int i = 0; i < SLOTS - 1; i++) begin
                    d.slot[i] = q.slot[i+1];
                end
                d.cnt = q.cnt - 1'b1;
            end
            if (push && DEPTH > 0 && int'(d.cnt) < SLOTS) begin
                for (int i = 0; i < SLOTS; i++) begin
                    if (i == int'(d.cnt)) d.slot[i] = din;
                end
                d.cnt = d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        head      = q.slot[0];
        empty     = (q.cnt == '0);
        full      = (DEPTH == 0) || (int'(q.cnt) == SLOTS);
        pend_mask = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (i < int'(q.cnt)) pend_mask[q.slot[i].idx] = 1'b1;
        end
    end

    // R7: a pop is only requested when an entry is waiting
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R5: the caller never pushes into a full queue without a pop
    p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R5: occupancy stays within the configured depth
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.cnt) <= SLOTS);

endmodule

// File: rtl/aer_hdr_log_queue.sv
module aer_hdr_log_queue
    import aer_log_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [STAT_W-1:0] rec_status,
    input  logic [LOG_W-1:0]  rec_hdr,
    input  logic              rec_hdr_ok,
    input  logic [LOG_W-1:0]  rec_pfx,
    input  logic              rec_pfx_ok,
    input  logic              pfx_en,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic              ctl_we,
    input  logic              ctl_mhr,
    output logic [STAT_W-1:0] uncor_status,
    output logic [IDX_W-1:0]  first_err_ptr,
    output logic [LOG_W-1:0]  hdr_log,
    output logic [LOG_W-1:0]  pfx_log,
    output logic              pfx_logged,
    output logic              mhr_enabled,
    output logic              mhr_capable,
    output logic              log_overflow
);

    localparam bit CAPABLE = (DEPTH > 0);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [IDX_W-1:0]  fep;
        logic [LOG_W-1:0]  hdr;
        logic [LOG_W-1:0]  pfx;
        logic              pfx_flag;
        logic              mhr;
        logic              ovf;
    } log_state_t;

    log_state_t q, d;

    err_entry_t        rec_entry, head;
    logic              q_empty, q_full;
    logic [STAT_W-1:0] pend;
    logic              do_push, do_pop, do_flush;
    logic [LOG_W-1:0]  head_hdr, head_pfx, rec_hdr_img, rec_pfx_img;
    logic              head_pf, rec_pf;
    logic [STAT_W-1:0] st_w;
    logic              mhr_w, wr_any;

    always_comb begin
        rec_entry.idx    = lowest_bit(rec_status);
        rec_entry.hdr    = rec_hdr;
        rec_entry.hdr_ok = rec_hdr_ok;
        rec_entry.pfx    = rec_pfx;
        rec_entry.pfx_ok = rec_pfx_ok;
    end

    errq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .flush     (do_flush),
        .din       (rec_entry),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full),
        .pend_mask (pend)
    );

    errlog_view u_head_view (
        .entry    (head),
        .pfx_en   (pfx_en),
        .hdr_img  (head_hdr),
        .pfx_img  (head_pfx),
        .pfx_flag (head_pf)
    );

    errlog_view u_rec_view (
        .entry    (rec_entry),
        .pfx_en   (pfx_en),
        .hdr_img  (rec_hdr_img),
        .pfx_img  (rec_pfx_img),
        .pfx_flag (rec_pf)
    );

    always_comb begin
        d        = q;
        d.ovf    = 1'b0;
        do_push  = 1'b0;
        do_pop   = 1'b0;
        do_flush = 1'b0;
        wr_any   = stat_we || ctl_we;
        st_w     = stat_we ? (q.status & ~stat_clr) : q.status;
        mhr_w    = ctl_we ? (ctl_mhr && CAPABLE) : q.mhr;

        // Software write: acknowledge, restore or discard.
        if (wr_any) begin
            if (!st_w[q.fep]) begin
                if (!mhr_w || q_empty) begin
                    d.fep      = '0;
                    d.hdr      = '0;
                    d.pfx      = '0;
                    d.pfx_flag = 1'b0;
                end else begin
                    st_w       = st_w | pend;
                    do_pop     = 1'b1;
                    d.fep      = head.idx;
                    d.hdr      = head_hdr;
                    d.pfx      = head_pfx;
                    d.pfx_flag = head_pf;
                end
            end else if (mhr_w) begin
                st_w = st_w | pend;
            end else begin
                do_flush = 1'b1;
            end
        end

        // Record, judged against the post-write state.
        if (rec_valid) begin
            if (mhr_w && st_w[d.fep]) begin
                if (q_full && !do_pop) d.ovf = 1'b1;
                else                   do_push = 1'b1;
            end else begin
                d.fep      = rec_entry.idx;
                d.hdr      = rec_hdr_img;
                d.pfx      = rec_pfx_img;
                d.pfx_flag = rec_pf;
            end
            st_w = st_w | rec_status;
        end

        d.status = st_w;
        d.mhr    = mhr_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign uncor_status  = q.status;
    assign first_err_ptr = q.fep;
    assign hdr_log       = q.hdr;
    assign pfx_log       = q.pfx;
    assign pfx_logged    = q.pfx_flag;
    assign mhr_enabled   = q.mhr;
    assign mhr_capable   = CAPABLE;
    assign log_overflow  = q.ovf;

    // R5: an overflow pulse only follows a record
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        log_overflow |-> $past(rec_valid));
    // R1: recorded status bits are set on the next cycle
    p_status_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> ((uncor_status & $past(rec_status)) == $past(rec_status)));
    // R10: with recording off and no write, the record becomes the view
    p_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !mhr_enabled && !stat_we && !ctl_we)
        |=> (first_err_ptr == lowest_bit($past(rec_status))));
    // R4: a queued record leaves the visible header untouched
    p_view_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && !wr_any) |=> $stable(hdr_log));
    // R8: queued entries keep their status bits after a non-acknowledging write
    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && mhr_w && q.status[q.fep] && !(stat_we && stat_clr[q.fep]))
        |=> ((uncor_status & $past(pend)) == $past(pend)));
    // R3: no prefix flag means an empty prefix image
    p_pfx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pfx_logged |-> (pfx_log == '0));
    // R9: recording cannot be enabled without a queue
    p_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mhr_capable |-> !mhr_enabled);

endmodule

// File: tb/sim_aer_hdr_log_queue.sv
module sim_aer_hdr_log_queue;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rec_valid = 1'b0;
    logic [31:0]  rec_status = '0;
    logic [127:0] rec_hdr = '0;
    logic         rec_hdr_ok = 1'b0;
    logic [127:0] rec_pfx = '0;
    logic         rec_pfx_ok = 1'b0;
    logic         pfx_en = 1'b0;
    logic         stat_we = 1'b0;
    logic [31:0]  stat_clr = '0;
    logic         ctl_we = 1'b0;
    logic         ctl_mhr = 1'b0;

    logic [31:0]  st0, st1;
    logic [4:0]   fp0, fp1;
    logic [127:0] hl0, pl0, hl1, pl1;
    logic         pf0, me0, mc0, ov0, pf1, me1, mc1, ov1;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    aer_hdr_log_queue #(.DEPTH(3)) u0 (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
        .rec_hdr(rec_hdr), .rec_hdr_ok(rec_hdr_ok), .rec_pfx(rec_pfx),
        .rec_pfx_ok(rec_pfx_ok), .pfx_en(pfx_en), .stat_we(stat_we),
        .stat_clr(stat_clr), .ctl_we(ctl_we), .ctl_mhr(ctl_mhr),
        .uncor_status(st0), .first_err_ptr(fp0), .hdr_log(hl0), .pfx_log(pl0),
        .pfx_logged(pf0), .mhr_enabled(me0), .mhr_capable(mc0), .log_overflow(ov0)
    );

    aer_hdr_log_queue #(.DEPTH(0)) u1 (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
        .rec_hdr(rec_hdr), .rec_hdr_ok(rec_hdr_ok), .rec_pfx(rec_pfx),
        .rec_pfx_ok(rec_pfx_ok), .pfx_en(pfx_en), .stat_we(stat_we),
        .stat_clr(stat_clr), .ctl_we(ctl_we), .ctl_mhr(ctl_mhr),
        .uncor_status(st1), .first_err_ptr(fp1), .hdr_log(hl1), .pfx_log(pl1),
        .pfx_logged(pf1), .mhr_enabled(me1), .mhr_capable(mc1), .log_overflow(ov1)
    );

    function automatic logic [127:0] hpat(input int b);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[32*i +: 32] = 32'(b + 1) * 32'h0103_0507 + 32'(i) * 32'h1020_4080;
        return r;
    endfunction

    function automatic logic [127:0] ppat(input int b);
        return hpat(b) ^ {4{32'hA5A5_5A5A}};
    endfunction

    function automatic logic [127:0] swap(input logic [127:0] x);
        logic [127:0] o;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            w = x[32*i +: 32];
            o[32*i +: 32] = {w[7:0], w[15:8], w[23:16], w[31:24]};
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rec(input int b, input logic hv, input logic pp);
        @(negedge clk);
        rec_valid  = 1'b1;
        rec_status = 32'h1 << b;
        rec_hdr    = hpat(b);
        rec_hdr_ok = hv;
        rec_pfx    = ppat(b);
        rec_pfx_ok = pp;
        @(negedge clk);
        rec_valid  = 1'b0;
    endtask

    task automatic wr_stat(input logic [31:0] m);
        @(negedge clk);
        stat_we  = 1'b1;
        stat_clr = m;
        @(negedge clk);
        stat_we  = 1'b0;
    endtask

    task automatic wr_ctl(input logic m);
        @(negedge clk);
        ctl_we  = 1'b1;
        ctl_mhr = m;
        @(negedge clk);
        ctl_we  = 1'b0;
    endtask

    function automatic logic [31:0] bm(input int b);
        return 32'h1 << b;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 status", st0, 0);
        check("R11 pointer", fp0, 0);
        check("R11 header", hl0, 0);
        check("R11 enable", me0, 0);
        check("R11 overflow", ov0, 0);
        check("R11 capable", mc0, 1);
        check("R11 capable depth0", mc1, 0);

        // R1 R10 R2: sweep every status bit, recording off
        exp = '0;
        for (int b = 0; b < 32; b++) begin
            rec(b, 1'b1, 1'b0);
            exp |= bm(b);
            check("R1 pointer", fp0, b);
            check("R1 status", st0, exp);
            check("R2 header image", hl0, swap(hpat(b)));
            check("R10 prefix flag", pf0, 0);
        end
        wr_stat('1);
        check("R6 pointer", fp0, 0);
        check("R6 header", hl0, 0);
        check("R6 status", st0, 0);

        // R3 prefix rules, R2 header-invalid
        pfx_en = 1'b1;
        rec(3, 1'b1, 1'b1);
        check("R3 flag set", pf0, 1);
        check("R3 prefix image", pl0, swap(ppat(3)));
        rec(4, 1'b1, 1'b0);
        check("R3 no prefix flag", pf0, 0);
        check("R3 no prefix image", pl0, 0);
        pfx_en = 1'b0;
        rec(5, 1'b1, 1'b1);
        check("R3 disabled flag", pf0, 0);
        check("R3 disabled image", pl0, 0);
        rec(6, 1'b0, 1'b1);
        check("R2 invalid header", hl0, 0);
        wr_stat('1);

        // R4 R5 R7 R8 queue behaviour, depth 3
        wr_ctl(1'b1);
        check("R8 enable", me0, 1);
        rec(5, 1'b1, 1'b0);
        check("R4 first", fp0, 5);
        rec(9, 1'b1, 1'b0);
        check("R4 pointer held", fp0, 5);
        check("R4 header held", hl0, swap(hpat(5)));
        rec(2, 1'b1, 1'b0);
        rec(14, 1'b1, 1'b0);
        check("R5 no overflow", ov0, 0);
        rec(20, 1'b1, 1'b0);
        check("R5 overflow pulse", ov0, 1);
        check("R5 status kept", st0, bm(5) | bm(9) | bm(2) | bm(14) | bm(20));
        @(negedge clk);
        check("R5 pulse ends", ov0, 0);
        wr_stat(bm(9) | bm(2));
        check("R8 restored", st0, bm(5) | bm(9) | bm(2) | bm(14) | bm(20));
        wr_stat(bm(5));
        check("R7 pop pointer", fp0, 9);
        check("R7 pop header", hl0, swap(hpat(9)));
        check("R7 status", st0, bm(9) | bm(2) | bm(14) | bm(20));
        wr_stat(bm(9));
        check("R7 second pop", fp0, 2);
        wr_stat(bm(2));
        check("R7 third pop", fp0, 14);
        wr_stat(bm(14));
        check("R6 empty pointer", fp0, 0);
        check("R6 empty header", hl0, 0);
        check("R6 status", st0, bm(20));

        // R8 discard when recording is switched off
        rec(3, 1'b1, 1'b0);
        check("R8 view", fp0, 3);
        rec(4, 1'b1, 1'b0);
        wr_ctl(1'b0);
        check("R8 disabled", me0, 0);
        check("R8 pointer kept", fp0, 3);
        wr_stat(bm(3));
        check("R8 discarded pointer", fp0, 0);
        check("R8 discarded header", hl0, 0);
        wr_stat('1);

        // R12 record in the same cycle as a popping write
        wr_ctl(1'b1);
        rec(6, 1'b1, 1'b0);
        rec(7, 1'b1, 1'b0);
        @(negedge clk);
        stat_we    = 1'b1;
        stat_clr   = bm(6);
        rec_valid  = 1'b1;
        rec_status = bm(8);
        rec_hdr    = hpat(8);
        rec_hdr_ok = 1'b1;
        rec_pfx_ok = 1'b0;
        @(negedge clk);
        stat_we    = 1'b0;
        rec_valid  = 1'b0;
        check("R12 pointer", fp0, 7);
        check("R12 status", st0, bm(7) | bm(8));
        wr_stat(bm(7));
        check("R12 queued after pop", fp0, 8);
        check("R12 header", hl0, swap(hpat(8)));

        // R9 zero-depth instance
        wr_stat('1);
        wr_ctl(1'b1);
        check("R9 enable stays off", me1, 0);
        rec(10, 1'b1, 1'b0);
        rec(11, 1'b1, 1'b0);
        check("R9 overwrite", fp1, 11);
        check("R9 no overflow", ov1, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule